// File: doc/BRIEF.md
# Pin Change Interrupt Controller

This block monitors a small group of general-purpose input pins and raises one shared interrupt request whenever an enabled pin changes level. Both directions count: low to high and high to low. Each pin first passes through a two-flop synchroniser. A change is then found by comparing the synchronised level with its value one cycle earlier, so one toggle gives one detection pulse.

The CPU reaches the block through a byte-wide register port. The port has an I/O address, a write strobe and a read strobe, and it exposes three registers:

- a per-pin select register, which picks the pins that take part;
- a group enable register, which gates the request;
- a sticky group flag, which records that a change happened.

The flag is set by hardware. Software clears it by writing a one to it, and the acknowledge input also clears it when the CPU enters the vector. The request output goes high only when the flag, the group enable and the CPU global interrupt bit are all 1.

Top module: `pinchg_irq`

## Requirements
- R1: After reset, all three registers read 0x00 and `irq_o` is 0.
- R2: The pin select register is at address 0x10. Bits 3:0 are read/write, with bit n selecting pin n. Bits 7:4 read as zero and ignore writes.
- R3: The group enable register (0x12) and the flag register (0x11) use only bit 0. Bits 7:1 of both read as zero and ignore writes. The enable bit is read/write.
- R4: A rising or a falling change on a selected pin sets the flag. The flag reads 1 three clock edges after the pin changes.
- R5: A change on a pin whose select bit is 0 does not set the flag.
- R6: Writing 0x11 with bit 0 = 1 clears the flag. Writing it with bit 0 = 0 leaves the flag unchanged.
- R7: A one-cycle pulse on `ack_i` clears the flag.
- R8: `irq_o` is combinational and equals flag AND enable AND `gie_i`. It falls in the cycle after the flag clears.
- R9: When a set event coincides with a write-one clear or an acknowledge, the set wins and the flag stays 1.
- R10: While the enable is 0, the flag still records changes and can still be cleared by writing a one, so software can poll it.
- R11: `rd_data_o` is 0x00 while `rd_en_i` is 0 or while the address matches none of the three registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; it is released synchronously inside the block |
| pin_i | input | 4 | Monitored pins (asynchronous) |
| addr_i | input | 6 | I/O register address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 8 | Read data (combinational) |
| gie_i | input | 1 | CPU global interrupt enable bit |
| ack_i | input | 1 | Vector entry acknowledge; clears the flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Errors in the synchroniser or in the previous-level register show up at the port as a wrong detection time, a missing detection or a doubled detection. The flag read three edges after a toggle exposes these at once. A wrong flag state reaches `irq_o` in the same cycle whenever the enable and `gie_i` are high. A lost select or enable bit is visible on the next read. The coincident set-and-clear cycle is driven on purpose, because a reversed priority there is the only sign of that fault.

// File: rtl/pinchg_pkg.sv
package pinchg_pkg;
  localparam int unsigned SEL_ADDR  = 'h10;
  localparam int unsigned FLAG_ADDR = 'h11;
  localparam int unsigned ENA_ADDR  = 'h12;
endpackage

// File: rtl/pinchg_rst_sync.sv
module pinchg_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) stage_q <= 2'b00;
    else          stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/pinchg_sync.sv
module pinchg_sync #(
  parameter int NPINS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] chg_o
);
  logic [NPINS-1:0] meta_q, lvl_q, prev_q;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b0;
        lvl_q[i]  <= 1'b0;
        prev_q[i] <= 1'b0;
      end else begin
        meta_q[i] <= pin_i[i];
        lvl_q[i]  <= meta_q[i];
        prev_q[i] <= lvl_q[i];
      end
    end
    assign chg_o[i] = lvl_q[i] ^ prev_q[i];
  end
endmodule

// File: rtl/pinchg_regs.sv
module pinchg_regs
  import pinchg_pkg::*;
#(
  parameter int NPINS = 4,
  parameter int AW    = 6,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr_i,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             rd_en_i,
  output logic [DW-1:0]    rd_data_o,
  input  logic [NPINS-1:0] chg_i,
  input  logic             ack_i,
  output logic [NPINS-1:0] sel_o,
  output logic             ena_o,
  output logic             flag_o
);
  logic [NPINS-1:0] sel_q, sel_d;
  logic             ena_q, ena_d, flag_q, flag_d;
  logic             sel_we, ena_we, flag_we;
  logic             hit_sel, hit_ena, hit_flag;
  logic             set_evt, clr_evt;

  assign hit_sel  = (addr_i == AW'(SEL_ADDR));
  assign hit_ena  = (addr_i == AW'(ENA_ADDR));
  assign hit_flag = (addr_i == AW'(FLAG_ADDR));

  always_comb begin
    sel_we  = wr_en_i && hit_sel;
    ena_we  = wr_en_i && hit_ena;
    sel_d   = wr_data_i[NPINS-1:0];
    ena_d   = wr_data_i[0];
    set_evt = |(chg_i & sel_q);
    clr_evt = ack_i || (wr_en_i && hit_flag && wr_data_i[0]);
    flag_we = set_evt || clr_evt;
    flag_d  = set_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      ena_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (sel_we)  sel_q  <= sel_d;
      if (ena_we)  ena_q  <= ena_d;
      if (flag_we) flag_q <= flag_d;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_en_i) begin
      if (hit_sel)       rd_data_o = {{(DW-NPINS){1'b0}}, sel_q};
      else if (hit_ena)  rd_data_o = {{(DW-1){1'b0}}, ena_q};
      else if (hit_flag) rd_data_o = {{(DW-1){1'b0}}, flag_q};
    end
  end

  assign sel_o  = sel_q;
  assign ena_o  = ena_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/pinchg_irq.sv
module pinchg_irq #(
  parameter int NPINS = 4,
  parameter int AW    = 6,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             rd_en_i,
  output logic [DW-1:0]    rd_data_o,
  input  logic             gie_i,
  input  logic             ack_i,
  output logic             irq_o
);
  logic             srst_n;
  logic [NPINS-1:0] chg_w, sel_w;
  logic             ena_w, flag_w;

  pinchg_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (srst_n)
  );

  pinchg_sync #(.NPINS(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (srst_n),
    .pin_i (pin_i),
    .chg_o (chg_w)
  );

  pinchg_regs #(.NPINS(NPINS), .AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (srst_n),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_en_i   (rd_en_i),
    .rd_data_o (rd_data_o),
    .chg_i     (chg_w),
    .ack_i     (ack_i),
    .sel_o     (sel_w),
    .ena_o     (ena_w),
    .flag_o    (flag_w)
  );

  assign irq_o = flag_w & ena_w & gie_i;
endmodule

// File: rtl/pinchg_irq_chk.sv
module pinchg_irq_chk #(
  parameter int NPINS = 4,
  parameter int AW    = 6,
  parameter int DW    = 8
) (
  input logic             clk,
  input logic             srst_n,
  input logic [NPINS-1:0] chg_w,
  input logic [NPINS-1:0] sel_w,
  input logic             ena_w,
  input logic             flag_w,
  input logic             ack_i,
  input logic             gie_i,
  input logic             wr_en_i,
  input logic [AW-1:0]    addr_i,
  input logic [DW-1:0]    wr_data_i,
  input logic [DW-1:0]    rd_data_o,
  input logic             irq_o
);
  logic hw_set, sw_clr;
  assign hw_set = |(chg_w & sel_w);
  assign sw_clr = wr_en_i && (addr_i == AW'('h11)) && wr_data_i[0];

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!srst_n)
    hw_set |=> flag_w);
  a_r5_no_spurious_set: assert property (@(posedge clk) disable iff (!srst_n)
    (!flag_w && !hw_set) |=> !flag_w);
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!srst_n)
    (ack_i && !hw_set) |=> !flag_w);
  a_r6_flag_holds: assert property (@(posedge clk) disable iff (!srst_n)
    (flag_w && !ack_i && !sw_clr) |=> flag_w);
  a_r8_irq_needs_gie: assert property (@(posedge clk) disable iff (!srst_n)
    irq_o |-> (gie_i && flag_w));
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!srst_n)
    rd_data_o[DW-1:NPINS] == '0);
endmodule

bind pinchg_irq pinchg_irq_chk #(.NPINS(NPINS), .AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .chg_w     (chg_w),
  .sel_w     (sel_w),
  .ena_w     (ena_w),
  .flag_w    (flag_w),
  .ack_i     (ack_i),
  .gie_i     (gie_i),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wr_data_i (wr_data_i),
  .rd_data_o (rd_data_o),
  .irq_o     (irq_o)
);

// File: tb/pinchg_irq_test.sv
module pinchg_irq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pin = '0;
  logic [5:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0, gie = 1'b0, ack = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;
  int         n_chk = 0, n_err = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  pinchg_irq uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wdata), .rd_en_i(rd_en), .rd_data_o(rdata), .gie_i(gie),
    .ack_i(ack), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic toggle(input int p);
    @(negedge clk); pin[p] = ~pin[p];
    repeat (3) @(posedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd('h10, v); chk("R1 sel", v, 8'h00);
    rd('h11, v); chk("R1 flag", v, 8'h00);
    rd('h12, v); chk("R1 ena", v, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    wr('h10, 8'hFA); rd('h10, v); chk("R2 sel rw", v, 8'h0A);
    wr('h10, 8'h05); rd('h10, v); chk("R2 sel rw2", v, 8'h05);
    wr('h12, 8'hFF); rd('h12, v); chk("R3 ena rw", v, 8'h01);
    wr('h12, 8'h00); rd('h12, v); chk("R3 ena clr", v, 8'h00);
    rd('h11, v); chk("R3 flag upper", v, 8'h00);
    rd('h13, v); chk("R11 unmapped", v, 8'h00);
    @(negedge clk); addr = 'h10; #1 chk("R11 no rd_en", rdata, 8'h00);
  endtask

  task automatic t_edges;
    logic [7:0] v;
    wr('h10, 8'h01);
    toggle(0); @(negedge clk); rd('h11, v); chk("R4 rising", v, 8'h01);
    wr('h11, 8'h01); rd('h11, v); chk("R6 w1c", v, 8'h00);
    toggle(0); @(negedge clk); rd('h11, v); chk("R4 falling", v, 8'h01);
    wr('h11, 8'hFE); rd('h11, v); chk("R6 write zero keeps", v, 8'h01);
    @(negedge clk); ack = 1'b1; @(negedge clk); ack = 1'b0;
    rd('h11, v); chk("R7 ack clears", v, 8'h00);
  endtask

  task automatic t_timing;
    wr('h10, 8'h02);
    @(negedge clk); pin[1] = 1'b1;
    repeat (2) @(posedge clk); @(negedge clk);
    rd_en = 1'b1; addr = 'h11; #1 chk("R4 not yet at 2 edges", rdata, 8'h00);
    @(negedge clk); #1 chk("R4 set at 3 edges", rdata, 8'h01);
    rd_en = 1'b0;
    wr('h11, 8'h01);
  endtask

  task automatic t_unmasked;
    logic [7:0] v;
    wr('h10, 8'h01);
    toggle(2); toggle(3); toggle(1);
    repeat (2) @(posedge clk);
    rd('h11, v); chk("R5 unselected pins", v, 8'h00);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    wr('h10, 8'h08);
    toggle(3); @(negedge clk);
    rd('h11, v); chk("R10 flag with ena=0", v, 8'h01);
    chk("R8 no irq ena=0", {7'b0, irq}, 8'h00);
    wr('h12, 8'h01); #1 chk("R8 no irq gie=0", {7'b0, irq}, 8'h00);
    gie = 1'b1; #1 chk("R8 irq all set", {7'b0, irq}, 8'h01);
    @(negedge clk); ack = 1'b1; #1 chk("R8 irq before clear", {7'b0, irq}, 8'h01);
    @(negedge clk); ack = 1'b0; #1 chk("R8 irq drops after clear", {7'b0, irq}, 8'h00);
    wr('h12, 8'h00); gie = 1'b0;
    toggle(3); wr('h11, 8'h01);
    rd('h11, v); chk("R10 w1c with ena=0", v, 8'h00);
  endtask

  task automatic t_set_wins;
    logic [7:0] v;
    wr('h10, 8'h01);
    @(negedge clk); pin[0] = ~pin[0];
    repeat (2) @(posedge clk);
    @(negedge clk); addr = 'h11; wdata = 8'h01; wr_en = 1'b1; ack = 1'b1;
    @(negedge clk); wr_en = 1'b0; ack = 1'b0;
    rd('h11, v); chk("R9 set beats clear", v, 8'h01);
    wr('h11, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_edges();
    t_timing();
    t_unmasked();
    t_irq();
    t_set_wins();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule